// File: doc/BRIEF.md
# GPIO Interrupt Source Controller

This block merges nine general-purpose input pins into a single host interrupt event. Each pin is first brought into the clock domain by a two-flop synchroniser. It can then pass through an optional debounce filter that only accepts a new level once that level has stayed unchanged for a set number of slow sample ticks. A detector then decides, per pin, whether the pin is asserting an interrupt. In level mode a chosen level (high or low) triggers. In edge mode a chosen edge (rising or falling) triggers, or either edge when the both-edges bit is set.

Any pin whose enable bit is set and whose detector fires sets one sticky event bit. The host clears that bit by writing 1 to it. Configuration is held in five 9-bit words on a simple register write/read port. The event bit appears both on a dedicated output and in a status word. Any write to a configuration word reloads the edge detectors and masks them for one cycle, so that changing mode, sense or filtering never produces an edge event by itself.

Top module: `gpirq_ctrl`

## Requirements
- R1: The configuration words are enable (address 0), mode (address 1, bit i = 1 selects edge mode for pin i), sense (address 2), both-edges (address 3) and debounce enable (address 4). Each word holds bit i for pin i, for i from 0 to 8. Bits 9 to 31 are not stored and read as 0.
- R2: Only a pin whose enable bit is 1 can set the event. Activity on a pin whose enable bit is 0 leaves the event unchanged.
- R3: After reset, all five configuration words read 0 and the event output is 0.
- R4: In level mode (mode bit 0), a pin triggers while its conditioned level equals its sense bit: sense 1 means active high, sense 0 means active low.
- R5: In edge mode (mode bit 1), a pin triggers on a rising edge when its sense bit is 1 and on a falling edge when its sense bit is 0. When its both-edges bit is 1, either edge triggers.
- R6: The event is sticky and is read at address 5, bit 0. Writing 1 to that bit clears it, and the clear takes priority over a trigger in the same cycle. Writing 0 has no effect.
- R7: In level mode, if the active level is still present after a clear, the event reads 0 for exactly one cycle and then sets again.
- R8: With debounce off, an edge applied before rising clock edge t makes the event output high after rising edge t+2 and not before.
- R9: With debounce on, a pin level is accepted only after it has differed from the accepted level for DB_COUNT consecutive sample ticks, with one tick every PRESCALE clocks. A pulse shorter than (DB_COUNT-1)*PRESCALE clocks causes no event.
- R10: A configuration write that switches a pin between its filtered and unfiltered level does not by itself raise an edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous GPIO inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for both write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the word at addr (combinational) |
| event_o | output | 1 | Sticky GPIO event toward the host |

## Verification
The sweep covers every pin with each of the five detector settings (level high, level low, rising, falling, both edges) and with both starting levels. A level that is already active is thereby told apart from a new transition, and a rising edge from a falling one. A second sweep keeps only one pin enabled and toggles all the other pins, which separates per-pin enables from a shared enable. Short and long pulses with debounce on, a filter switch made while a pin is mid-transition, and the exact three-edge latency check the filter, the masking of configuration writes and the pipeline depth.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN     = 3'd0,
    RA_MODE   = 3'd1,
    RA_SENSE  = 3'd2,
    RA_BOTH   = 3'd3,
    RA_DB     = 3'd4,
    RA_STATUS = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpirq_tick.sv
module gpirq_tick #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/gpirq_debounce.sv
module gpirq_debounce #(
  parameter int DB_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (DB_COUNT > 1) ? $clog2(DB_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_COUNT - 1);

  logic          stable_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      run_q    <= '0;
    end else if (d_i == stable_q) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (run_q == LAST) begin
        stable_q <= d_i;
        run_q    <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic hold_i,
  output logic trig_o
);
  logic prev_q;
  logic edge_hit, lvl_hit;

  // prev tracks the level every cycle, so a configuration write reloads it too
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    if (both_i)       edge_hit = lvl_i ^ prev_q;
    else if (sense_i) edge_hit = lvl_i & ~prev_q;
    else              edge_hit = ~lvl_i & prev_q;
    lvl_hit = (lvl_i == sense_i);
  end

  assign trig_o = en_i & (edge_mode_i ? (edge_hit & ~hold_i) : lvl_hit);
endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl
  import gpirq_pkg::*;
#(
  parameter int NPINS    = 9,
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 16,
  parameter int DB_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    pin_i,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                event_o
);
  logic [NPINS-1:0] en_q, mode_q, sense_q, both_q, db_q;
  logic [NPINS-1:0] sync_lvl, deb_lvl, cond_lvl, trig_vec;
  logic             cfg_wr, cfg_wr_q, clr, event_q, tick;
  logic [NPINS-1:0] wd;
  logic             unused_wdata_hi;

  assign wd              = wdata[NPINS-1:0];
  assign unused_wdata_hi = |wdata[DATA_W-1:NPINS];
  assign cfg_wr          = wr_en && (addr <= RA_DB);
  assign clr             = wr_en && (addr == RA_STATUS) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mode_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      db_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_EN:    en_q    <= wd;
        RA_MODE:  mode_q  <= wd;
        RA_SENSE: sense_q <= wd;
        RA_BOTH:  both_q  <= wd;
        RA_DB:    db_q    <= wd;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_wr_q <= 1'b0;
    else        cfg_wr_q <= cfg_wr;
  end

  gpirq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_lvl)
  );

  gpirq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpirq_debounce #(.DB_COUNT(DB_COUNT)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .d_i(sync_lvl[i]), .q_o(deb_lvl[i])
    );

    assign cond_lvl[i] = db_q[i] ? deb_lvl[i] : sync_lvl[i];

    gpirq_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl_i(cond_lvl[i]),
      .en_i(en_q[i]), .edge_mode_i(mode_q[i]), .sense_i(sense_q[i]),
      .both_i(both_q[i]), .hold_i(cfg_wr_q), .trig_o(trig_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          event_q <= 1'b0;
    else if (clr)        event_q <= 1'b0;
    else if (|trig_vec)  event_q <= 1'b1;
  end

  assign event_o = event_q;

  always_comb begin
    rdata = '0;
    case (addr)
      RA_EN:     rdata[NPINS-1:0] = en_q;
      RA_MODE:   rdata[NPINS-1:0] = mode_q;
      RA_SENSE:  rdata[NPINS-1:0] = sense_q;
      RA_BOTH:   rdata[NPINS-1:0] = both_q;
      RA_DB:     rdata[NPINS-1:0] = db_q;
      RA_STATUS: rdata[0]         = event_q;
      default:   ;
    endcase
  end
endmodule

// File: rtl/gpirq_ctrl_chk.sv
module gpirq_ctrl_chk #(
  parameter int NPINS  = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              event_o,
  input logic [NPINS-1:0]  trig_vec,
  input logic [NPINS-1:0]  en_q
);
  logic host_clr;
  assign host_clr = wr_en && (addr == 3'd5) && wdata[0];

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NPINS] == '0);

  p_no_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !event_o) |=> !event_o);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> !event_o);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && !host_clr) |=> event_o);

  p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(event_o) |-> $past(|trig_vec));
endmodule

bind gpirq_ctrl gpirq_ctrl_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .event_o(event_o), .trig_vec(trig_vec), .en_q(en_q)
);

// File: tb/test_gpirq_ctrl.sv
`timescale 1ns/1ps
module test_gpirq_ctrl;
  localparam int NP = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        event_o;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  gpirq_ctrl #(.NPINS(NP), .DATA_W(32), .PRESCALE(2), .DB_COUNT(4)) i_gpirq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .event_o(event_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[2:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = a[2:0];
    #1 d = rdata;
  endtask

  task automatic clear_all();
    wreg(0, 0); wreg(1, 0); wreg(2, 0); wreg(3, 0); wreg(4, 0);
    pins = '0;
    idle(12);
    wreg(5, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R3: reset state
    for (int a = 0; a < 6; a++) begin
      rreg(a, rd);
      chk($sformatf("R3 reset word %0d", a), rd, 32'h0);
    end
    chk("R3 reset event", {31'h0, event_o}, 32'h0);

    // R1: only 9 bits stored per word
    for (int a = 0; a < 5; a++) begin
      wreg(a, 32'hFFFF_FFFF);
      rreg(a, rd);
      chk($sformatf("R1 word %0d readback", a), rd, 32'h1FF);
      wreg(a, 32'hA5A5_A4B6);
      rreg(a, rd);
      chk($sformatf("R1 word %0d pattern", a), rd, 32'h0B6);
    end
    clear_all();

    // R4 R5: sweep pin x detector setting x starting level
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 5; c++) begin
        for (int v0 = 0; v0 < 2; v0++) begin
          logic m, s, b, ea, eb, v1;
          m = (c >= 2);
          s = (c == 0) || (c == 2);
          b = (c == 4);
          v1 = ~v0[0];
          wreg(0, 0);
          pins = '0;
          wreg(1, {31'h0, m} << p);
          wreg(2, {31'h0, s} << p);
          wreg(3, {31'h0, b} << p);
          pins[p] = v0[0];
          idle(6);
          wreg(0, 32'h1 << p);
          idle(4);
          wreg(5, 1);
          idle(3);
          ea = !m && (v0[0] == s);
          chk($sformatf("R4 p%0d c%0d v%0d initial", p, c, v0), {31'h0, event_o}, {31'h0, ea});
          pins[p] = v1;
          idle(6);
          eb = ea | (m ? (b | (v1 == s)) : (v1 == s));
          chk($sformatf("R5 p%0d c%0d v%0d after change", p, c, v0), {31'h0, event_o}, {31'h0, eb});
        end
      end
    end
    clear_all();

    // R2: only the enabled pin counts
    wreg(1, 32'h1FF);
    wreg(3, 32'h1FF);
    for (int p = 0; p < NP; p++) begin
      wreg(0, 32'h1 << p);
      pins = '0;
      idle(6);
      wreg(5, 1);
      pins = ~(9'h1 << p);
      idle(6);
      pins = '0;
      idle(6);
      chk($sformatf("R2 others toggled p%0d", p), {31'h0, event_o}, 32'h0);
      pins[p] = 1'b1;
      idle(6);
      chk($sformatf("R2 own pin p%0d", p), {31'h0, event_o}, 32'h1);
    end
    clear_all();

    // R8: latency, pin3 rising edge
    wreg(1, 32'h8); wreg(2, 32'h8); wreg(0, 32'h8);
    idle(4);
    wreg(5, 1);
    idle(2);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet after two edges", {31'h0, event_o}, 32'h0);
    @(negedge clk);
    chk("R8 set after third edge", {31'h0, event_o}, 32'h1);

    // R6: write 0 has no effect, write 1 clears
    wreg(5, 0);
    idle(2);
    chk("R6 write 0 keeps event", {31'h0, event_o}, 32'h1);
    rreg(5, rd);
    chk("R6 status word", rd, 32'h1);
    wreg(5, 1);
    idle(2);
    chk("R6 write 1 clears", {31'h0, event_o}, 32'h0);
    clear_all();

    // R7 R6: level re-set after clear, clear wins in its cycle
    wreg(2, 32'h2); wreg(0, 32'h2);
    pins[1] = 1'b1;
    idle(6);
    chk("R7 level active sets", {31'h0, event_o}, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wdata = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    chk("R7 R6 cleared for one cycle", {31'h0, event_o}, 32'h0);
    @(negedge clk);
    chk("R7 sets again next cycle", {31'h0, event_o}, 32'h1);
    clear_all();

    // R9: debounce, pin5 rising edge
    wreg(1, 32'h20); wreg(2, 32'h20); wreg(4, 32'h20); wreg(0, 32'h20);
    idle(20);
    wreg(5, 1);
    idle(2);
    pins[5] = 1'b1; idle(3); pins[5] = 1'b0;
    idle(20);
    chk("R9 short pulse filtered", {31'h0, event_o}, 32'h0);
    pins[5] = 1'b1;
    idle(20);
    chk("R9 long pulse accepted", {31'h0, event_o}, 32'h1);
    pins[5] = 1'b0;
    idle(20);
    // R9: level mode with debounce
    wreg(1, 0);
    idle(4);
    wreg(5, 1);
    idle(2);
    chk("R9 level mode idle", {31'h0, event_o}, 32'h0);
    pins[5] = 1'b1; idle(3); pins[5] = 1'b0;
    idle(20);
    chk("R9 level short pulse filtered", {31'h0, event_o}, 32'h0);
    clear_all();

    // R10: switching filter off mid-transition gives no edge
    wreg(1, 32'h1); wreg(2, 32'h1); wreg(4, 32'h1); wreg(0, 32'h1);
    idle(20);
    wreg(5, 1);
    idle(2);
    @(negedge clk); pins[0] = 1'b1;
    idle(3);
    wreg(4, 0);
    idle(10);
    chk("R10 no event from filter switch", {31'h0, event_o}, 32'h0);
    pins[0] = 1'b0; idle(10); pins[0] = 1'b1; idle(10);
    chk("R10 unfiltered edge still seen", {31'h0, event_o}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule